// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Four word registers are exposed: control/status at byte offset 0x0, counter at 0x4, timeout at 0x8 and window at 0xC. The counter register also acts as a command port. Software writes ordered pairs of magic words to it, either to reopen configuration or to restart the count. Any broken restart pair is treated as a fault.

Configuration is guarded by a lock. After an unlock pair, the control, timeout and window registers accept writes for a bounded number of bus cycles. The first control write closes the lock again and reports that the new settings are in force through a status bit. An update-permission bit decides whether configuration may be changed again after that first commit.

While counting is enabled, the counter advances once per tick of the selected source. When the count reaches the timeout value, the block sets a flag and raises a reset request. The reset request is also raised when a restart pair is broken, or when a restart arrives too early while a non-zero window is set. The reset request stays asserted until system reset.

Top module: `wdt_keyed`

## Requirements
- R1: Registers decode on byte address bits [3:2]: 0 control/status, 1 counter, 2 timeout, 3 window. Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`, and is held until the next read.
- R2: After reset, control/status reads 0x00000020 (update bit only), the counter reads 0, the timeout reads `TOVAL_RST`, the window reads 0, and `wdog_rst_req` is low.
- R3: Writing 0x0000C520 and then 0x0000D928 to the counter register unlocks configuration, and control/status bit 11 reads 1 while unlocked.
- R4: While locked, writes to the control, timeout and window registers leave them unchanged.
- R5: The unlocked state ends after `UNLOCK_CYCLES` clock cycles, or at the first accepted control write, whichever comes first.
- R6: An accepted control write applies bit 7 (count enable), bit 5 (update permission) and bits 9:8 (tick source) at once. Status bit 10 then reads 1, and it is cleared again by the next unlock.
- R7: Once a control write has been accepted with bit 5 clear, later writes to the control, timeout and window registers are ignored even while unlocked.
- R8: With bit 7 set, the counter advances by one per tick of the source chosen by bits 9:8. Source 0 ticks every clock cycle, 1 is `tick_lpo`, 2 is `tick_32k` and 3 is `tick_ext`. Ticks from the other sources have no effect.
- R9: When a tick brings the count to the timeout value, the counter holds there, control/status bit 14 sets, and `wdog_rst_req` asserts.
- R10: Writing 0x0000A602 and then 0x0000B480 to the counter register reloads the count to 0.
- R11: After 0x0000A602, any counter-register write other than 0x0000B480 asserts `wdog_rst_req`. A broken unlock pair is discarded without unlocking and without a fault.
- R12: With a non-zero window, a completed refresh while the count is below the window value asserts `wdog_rst_req`. With the window at 0, a refresh never faults.
- R13: `wdog_rst_req` stays asserted until `rst`. Bit 14 is cleared only by an accepted control write that has bit 14 set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_lpo | input | 1 | Low-power 1 kHz tick enable |
| tick_32k | input | 1 | 32 kHz tick enable |
| tick_ext | input | 1 | External tick enable |
| wdog_rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with `UNLOCK_CYCLES` set to 16, so that lock expiry can be observed within a few dozen cycles. It sets `TOVAL_RST` to 0x40, so that the reset value of the timeout register is distinct from every value the bench programs later. Timeouts are reprogrammed to small values (16 ticks) so that the count reaching its limit, window faults and refresh timing can all be reached through hand-pulsed external ticks. The every-cycle source is checked by the difference between two counter reads taken a known number of cycles apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] KEY_REFRESH_A = 32'h0000_A602;
  localparam logic [31:0] KEY_REFRESH_B = 32'h0000_B480;
  localparam logic [31:0] KEY_UNLOCK_A  = 32'h0000_C520;
  localparam logic [31:0] KEY_UNLOCK_B  = 32'h0000_D928;

  // control/status bit positions
  localparam int B_UPD  = 5;
  localparam int B_EN   = 7;
  localparam int B_SEL  = 8;
  localparam int B_RCS  = 10;
  localparam int B_ULK  = 11;
  localparam int B_FLAG = 14;

  // word index of each register (byte address bits [3:2])
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_TOV  = 2'd2,
    REG_WIN  = 2'd3
  } reg_idx_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_REF_A = 2'd1,
    SQ_UNL_A = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wdt_seq.sv
// Detects ordered magic-word pairs written to the counter register.
module wdt_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cnt,
  input  logic [31:0] wdata,
  output logic        refresh_p,
  output logic        unlock_p,
  output logic        fault_p
);
  seq_state_t st_q;

  // R10 / R3 / R11: second word decides the outcome
  assign refresh_p = wr_cnt && (st_q == SQ_REF_A) && (wdata == KEY_REFRESH_B);
  assign fault_p   = wr_cnt && (st_q == SQ_REF_A) && (wdata != KEY_REFRESH_B);
  assign unlock_p  = wr_cnt && (st_q == SQ_UNL_A) && (wdata == KEY_UNLOCK_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE;
    end else if (wr_cnt) begin
      if (st_q == SQ_IDLE) begin
        if (wdata == KEY_REFRESH_A)     st_q <= SQ_REF_A;
        else if (wdata == KEY_UNLOCK_A) st_q <= SQ_UNL_A;
      end else begin
        st_q <= SQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/wdt_cfg.sv
// Configuration registers, lock window and commit status.
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int          TO_W          = 16,
  parameter int          UNLOCK_CYCLES = 128,
  parameter logic [15:0] TOVAL_RST     = 16'h1500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctrl,
  input  logic            wr_tov,
  input  logic            wr_win,
  input  logic [31:0]     wdata,
  input  logic            unlock_p,
  input  logic            timeout_hit,
  output logic            ulk,
  output logic            rcs,
  output logic            en,
  output logic            upd,
  output logic [1:0]      sel,
  output logic            flag,
  output logic [TO_W-1:0] toval,
  output logic [TO_W-1:0] win
);
  localparam int TMR_W = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(UNLOCK_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             configured_q;
  logic             accept;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  // R4 / R7: write gate
  assign accept = ulk && (!configured_q || upd);

  always_ff @(posedge clk) begin
    if (rst) begin
      ulk          <= 1'b0;
      tmr_q        <= '0;
      rcs          <= 1'b0;
      configured_q <= 1'b0;
      en           <= 1'b0;
      upd          <= 1'b1;
      sel          <= 2'd0;
    end else if (unlock_p) begin
      ulk   <= 1'b1;
      tmr_q <= '0;
      rcs   <= 1'b0;
    end else if (wr_ctrl && accept) begin
      ulk          <= 1'b0;
      rcs          <= 1'b1;
      configured_q <= 1'b1;
      en           <= wdata[B_EN];
      upd          <= wdata[B_UPD];
      sel          <= wdata[B_SEL +: 2];
    end else if (ulk) begin
      if (tmr_q == TMR_LAST) ulk   <= 1'b0;  // R5
      else                   tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toval <= TO_W'(TOVAL_RST);
      win   <= '0;
      flag  <= 1'b0;
    end else begin
      if (wr_tov && accept) toval <= wdata[TO_W-1:0];
      if (wr_win && accept) win   <= wdata[TO_W-1:0];
      if (timeout_hit)                              flag <= 1'b1;
      else if (wr_ctrl && accept && wdata[B_FLAG]) flag <= 1'b0;  // R13
    end
  end
endmodule

// File: rtl/wdt_core.sv
// Tick counter, timeout compare, window check and sticky reset request.
module wdt_core #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic [TO_W-1:0] toval,
  input  logic [TO_W-1:0] win,
  input  logic            refresh_p,
  input  logic            fault_p,
  output logic [TO_W-1:0] cnt,
  output logic            hit,
  output logic            rst_req
);
  logic [TO_W:0] cnt_inc;
  logic          win_fault;

  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  // R9: tick that reaches the limit
  assign hit       = en && tick && !refresh_p && (cnt_inc >= {1'b0, toval});
  // R12: early refresh inside a non-zero window
  assign win_fault = refresh_p && (win != '0) && (cnt < win);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      if (refresh_p)                       cnt <= '0;
      else if (en && tick && cnt < toval) cnt <= cnt_inc[TO_W-1:0];
      if (hit || fault_p || win_fault)     rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int          AW            = 4,
  parameter int          TO_W          = 16,
  parameter int          UNLOCK_CYCLES = 128,
  parameter logic [15:0] TOVAL_RST     = 16'h1500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_lpo,
  input  logic          tick_32k,
  input  logic          tick_ext,
  output logic          wdog_rst_req
);
  reg_idx_t        idx;
  logic            wr_ctrl, wr_cnt, wr_tov, wr_win;
  logic            refresh_p, unlock_p, fault_p;
  logic            ulk, rcs, en, upd, flag, hit, tick;
  logic [1:0]      sel;
  logic [3:0]      tick_vec;
  logic [TO_W-1:0] toval, win, cnt_q;
  logic [31:0]     ctrl_rd, rd_mux;
  logic            unused_addr;

  assign unused_addr = ^bus_addr;
  assign idx     = reg_idx_t'(bus_addr[3:2]);  // R1
  assign wr_ctrl = bus_wr && (idx == REG_CTRL);
  assign wr_cnt  = bus_wr && (idx == REG_CNT);
  assign wr_tov  = bus_wr && (idx == REG_TOV);
  assign wr_win  = bus_wr && (idx == REG_WIN);

  wdt_seq u_seq (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wdata(bus_wdata),
    .refresh_p(refresh_p), .unlock_p(unlock_p), .fault_p(fault_p)
  );

  wdt_cfg #(.TO_W(TO_W), .UNLOCK_CYCLES(UNLOCK_CYCLES), .TOVAL_RST(TOVAL_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_tov(wr_tov), .wr_win(wr_win),
    .wdata(bus_wdata), .unlock_p(unlock_p), .timeout_hit(hit),
    .ulk(ulk), .rcs(rcs), .en(en), .upd(upd), .sel(sel), .flag(flag),
    .toval(toval), .win(win)
  );

  // R8: tick source select, index 0 = every cycle
  assign tick_vec = {tick_ext, tick_32k, tick_lpo, 1'b1};
  assign tick     = tick_vec[sel];

  wdt_core #(.TO_W(TO_W)) u_core (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .toval(toval), .win(win),
    .refresh_p(refresh_p), .fault_p(fault_p), .cnt(cnt_q), .hit(hit),
    .rst_req(wdog_rst_req)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[B_FLAG]     = flag;
    ctrl_rd[B_ULK]      = ulk;
    ctrl_rd[B_RCS]      = rcs;
    ctrl_rd[B_SEL +: 2] = sel;
    ctrl_rd[B_EN]       = en;
    ctrl_rd[B_UPD]      = upd;
    case (idx)
      REG_CTRL: rd_mux = ctrl_rd;
      REG_CNT:  rd_mux = 32'(cnt_q);
      REG_TOV:  rd_mux = 32'(toval);
      default:  rd_mux = 32'(win);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int TO_W          = 16,
  parameter int UNLOCK_CYCLES = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            ulk,
  input logic            unlock_p,
  input logic            refresh_p,
  input logic            rcs,
  input logic            flag,
  input logic            rst_req,
  input logic            wr_tov,
  input logic [TO_W-1:0] cnt,
  input logic [TO_W-1:0] toval
);
  logic [31:0] ulk_age;

  always_ff @(posedge clk) begin
    if (rst || unlock_p || !ulk) ulk_age <= '0;
    else                         ulk_age <= ulk_age + 1;
  end

  p_ulk_window_r5: assert property (@(posedge clk) disable iff (rst)
    ulk |-> (ulk_age < 32'(UNLOCK_CYCLES)));

  p_locked_tov_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_tov && !ulk) |=> $stable(toval));

  p_rcs_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    ulk |-> !rcs);

  p_flag_req_r9: assert property (@(posedge clk) disable iff (rst)
    flag |-> rst_req);

  p_refresh_zero_r10: assert property (@(posedge clk) disable iff (rst)
    refresh_p |=> (cnt == '0));

  p_req_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);
endmodule

bind wdt_keyed wdt_keyed_chk #(.TO_W(TO_W), .UNLOCK_CYCLES(UNLOCK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .ulk(ulk), .unlock_p(unlock_p), .refresh_p(refresh_p),
  .rcs(rcs), .flag(flag), .rst_req(wdog_rst_req), .wr_tov(wr_tov),
  .cnt(cnt_q), .toval(toval)
);

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
  localparam int UNL = 16;
  localparam logic [15:0] TRST = 16'h0040;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 ext ticks, 3 req check
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'h0, 32'h0,     32'h20,   4'd2},   // R2
    '{2'd1, 4'h8, 32'h0,     32'h40,   4'd2},   // R2
    '{2'd1, 4'hC, 32'h0,     32'h0,    4'd2},   // R2
    '{2'd3, 4'h0, 32'h0,     32'h0,    4'd2},   // R2
    '{2'd0, 4'h8, 32'h5,     32'h0,    4'd4},   // R4 locked write
    '{2'd1, 4'h8, 32'h0,     32'h40,   4'd4},   // R4
    '{2'd0, 4'h4, 32'hC520,  32'h0,    4'd3},   // R3
    '{2'd0, 4'h4, 32'hD928,  32'h0,    4'd3},   // R3
    '{2'd1, 4'h0, 32'h0,     32'h820,  4'd3},   // R3
    '{2'd0, 4'h8, 32'h10,    32'h0,    4'd1},   // R1
    '{2'd1, 4'h8, 32'h0,     32'h10,   4'd1},   // R1
    '{2'd0, 4'h0, 32'h3A0,   32'h0,    4'd6},   // R6
    '{2'd1, 4'h0, 32'h0,     32'h7A0,  4'd6},   // R6
    '{2'd0, 4'h8, 32'h7,     32'h0,    4'd5},   // R5 relocked
    '{2'd1, 4'h8, 32'h0,     32'h10,   4'd5},   // R5
    '{2'd2, 4'h0, 32'd5,     32'h0,    4'd8},   // R8
    '{2'd1, 4'h4, 32'h0,     32'h5,    4'd8},   // R8
    '{2'd0, 4'h4, 32'hA602,  32'h0,    4'd10},  // R10
    '{2'd0, 4'h4, 32'hB480,  32'h0,    4'd10},  // R10
    '{2'd1, 4'h4, 32'h0,     32'h0,    4'd10},  // R10
    '{2'd3, 4'h0, 32'h0,     32'h0,    4'd10},  // R10
    '{2'd2, 4'h0, 32'd16,    32'h0,    4'd9},   // R9
    '{2'd1, 4'h4, 32'h0,     32'h10,   4'd9},   // R9
    '{2'd1, 4'h0, 32'h0,     32'h47A0, 4'd9},   // R9
    '{2'd3, 4'h0, 32'h0,     32'h1,    4'd9}    // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_lpo = 1'b0, tick_32k = 1'b0, tick_ext = 1'b0;
  logic        wdog_rst_req;
  int checks = 0, fails = 0;
  logic [31:0] rv, rv2;

  always #4 clk = ~clk;

  wdt_keyed #(.AW(4), .TO_W(16), .UNLOCK_CYCLES(UNL), .TOVAL_RST(TRST)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_lpo(tick_lpo),
    .tick_32k(tick_32k), .tick_ext(tick_ext), .wdog_rst_req(wdog_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      if (src == 1) tick_lpo = 1'b1;
      else if (src == 2) tick_32k = 1'b1;
      else tick_ext = 1'b1;
      @(negedge clk);
      tick_lpo = 1'b0; tick_32k = 1'b0; tick_ext = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic unlock();
    wr(4'h4, 32'hC520);
    wr(4'h4, 32'hD928);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: begin rd(VEC[i].addr, rv); check(tag, rv, VEC[i].exp); end
        2'd2: pulse(3, int'(VEC[i].data));
        default: check(tag, 32'(wdog_rst_req), VEC[i].exp);
      endcase
    end

    // R13: flag clear by write-one, request stays
    unlock();
    wr(4'h0, 32'h43A0);
    rd(4'h0, rv); check("R13 flag cleared", rv, 32'h7A0);
    check("R13 req sticky", 32'(wdog_rst_req), 32'h1);

    // R11: broken refresh pair
    do_reset();
    wr(4'h4, 32'hA602);
    wr(4'h4, 32'h1234);
    check("R11 broken refresh", 32'(wdog_rst_req), 32'h1);
    repeat (20) @(negedge clk);
    check("R13 req held", 32'(wdog_rst_req), 32'h1);
    do_reset();
    check("R13 req cleared by rst", 32'(wdog_rst_req), 32'h0);

    // R11: broken unlock pair is discarded
    wr(4'h4, 32'hC520);
    wr(4'h4, 32'h1111);
    wr(4'h4, 32'hD928);
    rd(4'h0, rv); check("R11 broken unlock", rv, 32'h20);
    check("R11 no fault", 32'(wdog_rst_req), 32'h0);

    // R5: lock expiry
    unlock();
    repeat (UNL + 4) @(negedge clk);
    wr(4'h8, 32'h33);
    rd(4'h8, rv); check("R5 expired write", rv, 32'h40);
    rd(4'h0, rv); check("R5 ulk low", rv, 32'h20);

    // R7: update permission cleared
    unlock();
    wr(4'h0, 32'h380);
    rd(4'h0, rv); check("R7 ctrl", rv, 32'h780);
    unlock();
    wr(4'h8, 32'h9);
    rd(4'h8, rv); check("R7 tov frozen", rv, 32'h40);

    // R12: window fault
    do_reset();
    unlock(); wr(4'h8, 32'h100); wr(4'hC, 32'h8); wr(4'h0, 32'h3A0);
    pulse(3, 3);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    check("R12 early refresh", 32'(wdog_rst_req), 32'h1);

    // R12: refresh at or above window is fine
    do_reset();
    unlock(); wr(4'h8, 32'h100); wr(4'hC, 32'h8); wr(4'h0, 32'h3A0);
    pulse(3, 9);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    check("R12 late refresh", 32'(wdog_rst_req), 32'h0);
    rd(4'h4, rv); check("R12 count reloaded", rv, 32'h0);

    // R8: source 1 counts only tick_lpo
    do_reset();
    unlock(); wr(4'h8, 32'h100); wr(4'h0, 32'h1A0);
    pulse(3, 4); pulse(2, 3); pulse(1, 2);
    rd(4'h4, rv); check("R8 lpo source", rv, 32'h2);

    // R8: source 0 counts every cycle
    do_reset();
    unlock(); wr(4'h8, 32'h1000); wr(4'h0, 32'h0A0);
    rd(4'h4, rv);
    repeat (9) @(negedge clk);
    rd(4'h4, rv2);
    check("R8 bus clock source", rv2 - rv, 32'd10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule